// File: doc/BRIEF.md
# Serial Symbol Output Stage for a Parallel Rice-Code Decoder

This block is the last stage of a parallel Rice-code decoder. A word arrives on a load handshake as N entries, each with a prefix length and an empty flag. The entries go into a parallel-in serial-out register. They are then read out one per clock, with entry 0 first. The suffix bits for the stream arrive separately, in fixed-width chunks, and collect in a suffix shift register.

For each occupied entry, the block takes the next K suffix bits, places them below the prefix length to form one decoded symbol, and pulses a write strobe toward a downstream FIFO. An empty entry uses up one clock. It writes nothing and takes no suffix bits. The block stalls on the current entry while the FIFO reports full or while fewer than K suffix bits are held. It runs on a single clock that must be fast enough to retire up to N symbols per word period.

Top module: `sym_serializer`

## Requirements
- R1: While reset is asserted and directly after it, `ld_ready_o` and `suf_ready_o` are high and `fifo_wr_o` is low.
- R2: A word is taken in only on a clock where `ld_valid_i` and `ld_ready_o` are both high. `ld_ready_o` is high only when no entry of the previous word remains. A word offered while `ld_ready_o` is low is ignored and never reaches the output.
- R3: Entries are presented in index order, starting at entry 0. Entry i uses `ld_len_i[i*LW +: LW]` and `ld_empty_i[i]`, and a new entry becomes current at most once per clock.
- R4: An empty entry (`ld_empty_i[i]` = 1) produces no write and consumes no suffix bits. It retires in exactly one clock, whatever the FIFO full and suffix state.
- R5: An occupied entry produces exactly one write with `fifo_data_o = {length, suffix}`. The length is in the upper LW bits and the K suffix bits are in the lower bits, with the earliest stream bit at bit 0.
- R6: The suffix register drops exactly K bits on each write and no bits on any other clock.
- R7: `suf_ready_o` is high exactly when fewer than K suffix bits are held. An accepted chunk is appended after the held bits, and `suf_data_i` bit 0 is the earliest bit of the chunk in the stream.
- R8: While `fifo_full_i` is high, `fifo_wr_o` is low and the current occupied entry is held.
- R9: While fewer than K suffix bits are held, an occupied entry is held and no write occurs.
- R10: A word whose entries are all empty frees the load port after N clocks, so `ld_ready_o` is high again N+1 clocks after the load is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Word offered |
| ld_ready_o | output | 1 | All entries of the previous word retired |
| ld_len_i | input | N*LW | Prefix lengths, entry i at [i*LW +: LW] |
| ld_empty_i | input | N | Empty flags, entry i at bit i |
| suf_valid_i | input | 1 | Suffix chunk offered |
| suf_ready_o | output | 1 | Fewer than K suffix bits held |
| suf_data_i | input | SUF_W | Suffix chunk, earliest bit at bit 0 |
| fifo_full_i | input | 1 | Downstream FIFO cannot accept |
| fifo_wr_o | output | 1 | Symbol write strobe |
| fifo_data_o | output | LW+K | Decoded symbol {length, suffix} |

## Verification
The bench uses N=4, LW=3, K=3 and SUF_W=7. Because the chunk width is not a multiple of K, suffix fields regularly straddle two chunks, which exercises the append logic. Four entries per word keep load turnarounds frequent, so loads offered while the register is busy and all-empty words occur many times. Three-bit lengths make the all-zero and all-ones prefix values easy to drive.

// File: rtl/sym_serializer_pkg.sv
package sym_serializer_pkg;
  // width of a counter able to hold 0..v
  function automatic int cnt_w(input int v);
    return (v < 1) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/sym_piso.sv
module sym_piso #(
  parameter int N  = 8,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [N*LW-1:0] len_i,
  input  logic [N-1:0]  empty_i,
  output logic [LW-1:0] head_len_o,
  output logic          head_empty_o
);
  logic [LW-1:0] len_q [N];
  logic [N-1:0]  emp_q;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic [LW-1:0] up_len;
    logic          up_emp;
    if (i == N - 1) begin : g_top
      assign up_len = '0;
      assign up_emp = 1'b1;
    end else begin : g_mid
      assign up_len = len_q[i+1];
      assign up_emp = emp_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_q[i] <= '0;
        emp_q[i] <= 1'b1;
      end else if (load_i) begin
        len_q[i] <= len_i[i*LW +: LW];
        emp_q[i] <= empty_i[i];
      end else if (shift_i) begin
        len_q[i] <= up_len;
        emp_q[i] <= up_emp;
      end
    end
  end

  assign head_len_o   = len_q[0];
  assign head_empty_o = emp_q[0];
endmodule

// File: rtl/sym_suffix_sr.sv
module sym_suffix_sr #(
  parameter int K     = 2,
  parameter int SUF_W = 16,
  localparam int SR_W = SUF_W + K - 1,
  localparam int CW   = sym_serializer_pkg::cnt_w(SR_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             fill_i,
  input  logic [SUF_W-1:0] data_i,
  output logic [K-1:0]     bits_o,
  output logic             avail_o,
  output logic             ready_o,
  output logic [CW-1:0]    cnt_o
);
  logic [SR_W-1:0] sr_q;
  logic [CW-1:0]   cnt_q;

  // pop needs cnt>=K, fill needs cnt<K: never both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (pop_i) begin
      sr_q  <= sr_q >> K;
      cnt_q <= cnt_q - CW'(K);
    end else if (fill_i) begin
      sr_q  <= sr_q | (SR_W'(data_i) << cnt_q);
      cnt_q <= cnt_q + CW'(SUF_W);
    end
  end

  assign bits_o  = sr_q[K-1:0];
  assign avail_o = cnt_q >= CW'(K);
  assign ready_o = ~avail_o;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sym_serializer.sv
module sym_serializer #(
  parameter int N     = 8,
  parameter int LW    = 4,
  parameter int K     = 2,
  parameter int SUF_W = 16,
  localparam int SW   = LW + K,
  localparam int RW   = sym_serializer_pkg::cnt_w(N),
  localparam int CW   = sym_serializer_pkg::cnt_w(SUF_W + K - 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_valid_i,
  output logic            ld_ready_o,
  input  logic [N*LW-1:0] ld_len_i,
  input  logic [N-1:0]    ld_empty_i,
  input  logic            suf_valid_i,
  output logic            suf_ready_o,
  input  logic [SUF_W-1:0] suf_data_i,
  input  logic            fifo_full_i,
  output logic            fifo_wr_o,
  output logic [SW-1:0]   fifo_data_o
);
  logic [RW-1:0] rem_q;
  logic          busy, load, adv, wr;
  logic [LW-1:0] head_len;
  logic          head_empty;
  logic [K-1:0]  suf_bits;
  logic          suf_avail;
  logic [CW-1:0] suf_cnt;

  assign busy = rem_q != '0;
  assign load = ld_valid_i & ~busy;
  assign wr   = busy & ~head_empty & suf_avail & ~fifo_full_i;
  assign adv  = busy & (head_empty | wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rem_q <= '0;
    else if (load) rem_q <= RW'(N);
    else if (adv)  rem_q <= rem_q - RW'(1);
  end

  sym_piso #(.N(N), .LW(LW)) u_piso (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .shift_i      (adv),
    .len_i        (ld_len_i),
    .empty_i      (ld_empty_i),
    .head_len_o   (head_len),
    .head_empty_o (head_empty)
  );

  sym_suffix_sr #(.K(K), .SUF_W(SUF_W)) u_suf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pop_i   (wr),
    .fill_i  (suf_valid_i & suf_ready_o),
    .data_i  (suf_data_i),
    .bits_o  (suf_bits),
    .avail_o (suf_avail),
    .ready_o (suf_ready_o),
    .cnt_o   (suf_cnt)
  );

  assign ld_ready_o  = ~busy;
  assign fifo_wr_o   = wr;
  assign fifo_data_o = {head_len, suf_bits};
endmodule

// File: rtl/sym_serializer_chk.sv
module sym_serializer_chk #(
  parameter int LW    = 4,
  parameter int K     = 2,
  parameter int SUF_W = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_valid_i,
  input logic          ld_ready_o,
  input logic          suf_valid_i,
  input logic          suf_ready_o,
  input logic          fifo_full_i,
  input logic          fifo_wr_o,
  input logic [LW+K-1:0] fifo_data_o,
  input logic          head_empty,
  input logic          suf_avail,
  input logic [CW-1:0] suf_cnt
);
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ready_o |-> !fifo_wr_o); // R2
  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_ready_o) |=> !ld_ready_o); // R2
  AST_EMPTY_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_empty |-> !fifo_wr_o); // R4
  AST_POP_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |=> (suf_cnt == $past(suf_cnt) - CW'(K))); // R6
  AST_FILL_APPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suf_valid_i && suf_ready_o) |=> (suf_cnt == $past(suf_cnt) + CW'(SUF_W))); // R7
  AST_FULL_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !fifo_wr_o); // R8
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_i && !ld_ready_o && !head_empty) |=>
      (!ld_ready_o && $stable(fifo_data_o[LW+K-1:K]))); // R8
  AST_STARVE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !suf_avail |-> !fifo_wr_o); // R9
endmodule

bind sym_serializer sym_serializer_chk #(
  .LW(LW), .K(K), .SUF_W(SUF_W), .CW(CW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_valid_i  (ld_valid_i),
  .ld_ready_o  (ld_ready_o),
  .suf_valid_i (suf_valid_i),
  .suf_ready_o (suf_ready_o),
  .fifo_full_i (fifo_full_i),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_data_o (fifo_data_o),
  .head_empty  (head_empty),
  .suf_avail   (suf_avail),
  .suf_cnt     (suf_cnt)
);

// File: tb/sym_serializer_tb_top.sv
module sym_serializer_tb_top;
  localparam int N = 4, LW = 3, K = 3, SUF_W = 7;
  localparam int SW = LW + K;
  localparam int NW = 150;
  localparam int LIMIT = 20000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ld_valid_i = 1'b0, suf_valid_i = 1'b0, fifo_full_i = 1'b0;
  logic [N*LW-1:0] ld_len_i = '0;
  logic [N-1:0] ld_empty_i = '0;
  logic [SUF_W-1:0] suf_data_i = '0;
  logic ld_ready_o, suf_ready_o, fifo_wr_o;
  logic [SW-1:0] fifo_data_o;

  always #2ns clk_i = ~clk_i;

  sym_serializer #(.N(N), .LW(LW), .K(K), .SUF_W(SUF_W)) dut_i (.*);

  int total = 0, bad = 0;
  logic [N*LW-1:0] wlen [NW];
  logic [N-1:0]    wemp [NW];
  bit              sbits [$];
  logic [SW-1:0]   expq [$];

  function automatic logic [SW-1:0] make_sym(input logic [LW-1:0] l, input logic [K-1:0] s);
    return {l, s};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build();
    for (int w = 0; w < NW; w++) begin
      for (int i = 0; i < N; i++) begin
        logic [LW-1:0] l;
        logic [K-1:0]  s;
        bit e;
        case (w)
          0: begin e = 1; l = LW'($urandom); s = '0; end
          1: begin e = 0; l = '0; s = '0; end
          2: begin e = 0; l = '1; s = '1; end
          default: begin e = ($urandom % 4) == 0; l = LW'($urandom); s = K'($urandom); end
        endcase
        wlen[w][i*LW +: LW] = l;
        wemp[w][i] = e;
        if (!e) begin
          for (int b = 0; b < K; b++) sbits.push_back(s[b]);
          expq.push_back(make_sym(l, s));
        end
      end
    end
    while (sbits.size() % SUF_W != 0) sbits.push_back(1'b0);
  endtask

  initial begin
    int cyc = 0, wi = 0, c0 = 0;
    bit wait_drain = 0, done = 0;
    void'($urandom(32'd7741));
    build();
    repeat (3) begin
      @(negedge clk_i); #1;
      check(ld_ready_o && suf_ready_o && !fifo_wr_o, "R1 reset",
            {ld_ready_o, suf_ready_o, fifo_wr_o}, 3'b110);
    end
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check(ld_ready_o && suf_ready_o && !fifo_wr_o, "R1 after reset",
          {ld_ready_o, suf_ready_o, fifo_wr_o}, 3'b110);
    while (!done && cyc < LIMIT) begin
      @(negedge clk_i);
      cyc++;
      ld_valid_i = 1'b0;
      if (ld_ready_o && wait_drain) begin
        check(cyc - c0 == N + 1, "R10 all-empty drain", cyc - c0, N + 1);
        wait_drain = 0;
      end
      if (ld_ready_o) begin
        if (wi < NW && (wi < 3 || ($urandom % 4) != 0)) begin
          ld_valid_i = 1'b1;
          ld_len_i = wlen[wi];
          ld_empty_i = wemp[wi];
          if (wi == 0) begin c0 = cyc; wait_drain = 1; end
          wi++;
        end
      end else if (($urandom % 3) == 0) begin
        // offered while busy: must be ignored (R2)
        ld_valid_i = 1'b1;
        ld_len_i = (N*LW)'($urandom);
        ld_empty_i = N'($urandom);
      end
      suf_valid_i = 1'b0;
      if (suf_ready_o && sbits.size() >= SUF_W && ($urandom % 10) < 7) begin
        suf_valid_i = 1'b1;
        for (int b = 0; b < SUF_W; b++) suf_data_i[b] = sbits.pop_front();
      end
      fifo_full_i = (cyc >= 300 && cyc < 340) ? 1'b1 : (($urandom % 10) < 3);
      #1;
      if (fifo_full_i) check(!fifo_wr_o, "R8 write under full", fifo_wr_o, 0);
      if (fifo_wr_o) begin
        if (expq.size() == 0) check(0, "R2 R5 unexpected write", fifo_data_o, 0);
        else begin
          logic [SW-1:0] e;
          e = expq.pop_front();
          check(fifo_data_o == e, "R3 R4 R5 R6 R7 R9 symbol", fifo_data_o, e);
        end
      end
      if (wi == NW && expq.size() == 0 && ld_ready_o) done = 1;
    end
    if (!done) check(0, "R5 watchdog: symbols left", expq.size(), 0);
    else check(expq.size() == 0 && !wait_drain, "R5 all symbols written", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule